// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one complete NAND flash operation each time software launches it. A single launch walks the flash bus through every phase in turn. It sends the first opcode with the command latch high, then a programmable number of address bytes with the address latch high. Next comes an optional read or write data phase, then an optional confirm opcode. After that it waits out a programmable settle delay and polls ready/busy. Two-step flash operations therefore need only one launch, because the confirm opcode (program, erase, read start, random output start) comes from a separate register that has its own enable. The block also drives one of two active-low chip enables for the whole operation.

Software first sets the column and row address, the byte count, the confirm register and the settle delay. It then writes the control word with the start bit set. Read bytes appear on a one-cycle valid strobe. Write bytes are taken from a byte input, and a pop strobe marks each one as consumed. When the device reports ready, a sticky done flag is set. If a launch arrives while an operation is running, it is dropped and a sticky error flag is set. Software clears each flag by writing one to its bit.

Top module: `nand_seq`

## Requirements
- R1: Writing the control word with bit 31 set while idle starts an operation, and `busy` rises on the next clock. A write with bit 31 clear has no effect, and the bus stays idle.
- R2: Every bus byte takes two clocks: a strobe-low clock and then a strobe-high clock. The first byte is the opcode in control bits 7:0, driven with `nand_cle` high and `nand_we_n` pulsed.
- R3: Control bits 30:27 give the number of address bytes. If bit 30 is 0, there are no address bytes. If bit 30 is 1, the count is bits 29:27 plus one, capped at 5.
- R4: Address bytes go out with `nand_ale` high in this order: column low byte, column high byte, then row bytes from low to high.
- R5: Control bit 26 selects a read phase of `data_len` bytes using `nand_re_n` strobes. Each byte on `nand_dq_in` is sampled at the end of its strobe-low clock and shown on `rd_byte` with `rd_valid` during the next clock. If bits 26 and 25 are both set, the phase is a read.
- R6: Control bit 25 alone selects a write phase of `data_len` bytes. `wr_byte` is driven on `nand_dq_out` for both clocks of a byte, and `wr_pop` is high on the second clock.
- R7: If `data_len` is zero, or neither direction bit is set, there is no data phase.
- R8: When `cmd2_word` bit 8 is set, the opcode in bits 7:0 follows the address and data phases as a command-latch byte. When bit 8 is clear, that byte is omitted.
- R9: Control bit 19 selects the chip enable: 1 drives `nand_ce_n[1]` low, 0 drives `nand_ce_n[0]` low. The chosen enable is held for the whole operation. Both enables are high when idle.
- R10: After the last command-latch byte, `nand_rb` is ignored for `twb_cycles`+1 clocks. It is then sampled every clock. The operation ends, and `done_flag` rises, on the clock after `nand_rb` is seen high.
- R11: `done_flag` stays set until an `irq_we` write with bit 31 set. That write clears it on the next clock. Writes with bit 31 clear leave it set.
- R12: A start write that arrives while busy does not disturb the running operation. It sets `err_flag`, which is cleared by an `irq_we` write with bit 30 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_word | input | 32 | Control word: start, direction, address count, chip select, opcode |
| col_addr | input | 16 | Column address |
| row_addr | input | 24 | Row (page) address |
| data_len | input | 12 | Data phase byte count |
| cmd2_word | input | 9 | Confirm opcode (7:0) and its enable (8) |
| twb_cycles | input | 8 | Settle delay before ready/busy is sampled |
| irq_we | input | 1 | Flag clear write strobe |
| irq_wdata | input | 32 | Write-one-to-clear data: bit 31 done, bit 30 error |
| wr_byte | input | 8 | Next byte to write |
| wr_pop | output | 1 | Write byte consumed |
| rd_valid | output | 1 | Read byte valid |
| rd_byte | output | 8 | Read byte |
| nand_ce_n | output | 2 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Flash data bus out |
| nand_dq_oe | output | 1 | Flash data bus drive enable |
| nand_dq_in | input | 8 | Flash data bus in |
| nand_rb | input | 1 | Ready (1) / busy (0) |
| busy | output | 1 | Operation in progress |
| done_flag | output | 1 | Sticky completion flag |
| err_flag | output | 1 | Sticky launch-while-busy flag |

## Verification
The start write is captured on a rising edge, and the opcode strobe is visible on the next clock. From then on, every bus byte occupies exactly two clocks. A read byte appears one clock after its strobe-low clock. `done_flag` rises one clock after ready is sampled high, and each flag clears one clock after its clear write. The bench expands every launch into a per-clock list of expected bus values before the first strobe appears. It drives ready/busy and read data from that same list, and it compares every output on each falling edge, so each result is checked in the exact clock it is due.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD1, ST_ADDR, ST_DATA, ST_CMD2, ST_TWB, ST_WAIT
  } seq_state_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic       cs;
    logic       rd;
    logic       wr;
    logic [2:0] naddr;
  } op_cfg_t;

  localparam int unsigned CW_GO     = 31;
  localparam int unsigned CW_ACNT_H = 30;
  localparam int unsigned CW_ACNT_L = 27;
  localparam int unsigned CW_RD     = 26;
  localparam int unsigned CW_WR     = 25;
  localparam int unsigned CW_CS     = 19;
  localparam int unsigned C2_EN     = 8;
  localparam int unsigned IRQ_DONE  = 31;
  localparam int unsigned IRQ_ERR   = 30;

endpackage

// File: rtl/nand_seq_decode.sv
module nand_seq_decode
  import nand_seq_pkg::*;
#(
  parameter int ADDR_MAX = 5
) (
  input  logic [31:0] word,
  output logic        go,
  output op_cfg_t     cfg
);

  logic [3:0] acnt;
  logic [3:0] acnt_p1;
  logic       unused_word;

  assign acnt        = word[CW_ACNT_H:CW_ACNT_L];
  assign acnt_p1     = {1'b0, acnt[2:0]} + 4'd1;
  assign go          = word[CW_GO];
  assign unused_word = ^{word[24:20], word[18:8]};

  always_comb begin
    cfg.opcode = word[7:0];
    cfg.cs     = word[CW_CS];
    cfg.rd     = word[CW_RD];
    cfg.wr     = word[CW_WR];
    if (!acnt[3])
      cfg.naddr = 3'd0;
    else if (acnt_p1 > 4'(ADDR_MAX))
      cfg.naddr = 3'(ADDR_MAX);
    else
      cfg.naddr = acnt_p1[2:0];
  end

endmodule

// File: rtl/nand_seq_flags.sv
module nand_seq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done_set,
  input  logic err_set,
  input  logic clr_we,
  input  logic clr_done,
  input  logic clr_err,
  output logic done_q,
  output logic err_q
);

  logic done_d;
  logic err_d;

  always_comb begin
    done_d = done_set | (done_q & ~(clr_we & clr_done));
    err_d  = err_set  | (err_q  & ~(clr_we & clr_err));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(clr_we && clr_done)) |=> done_q);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(clr_we && clr_err)) |=> err_q);

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int COL_W = 16,
  parameter int ROW_W = 24,
  parameter int LEN_W = 12,
  parameter int TWB_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  op_cfg_t          cfg_in,
  input  logic [COL_W-1:0] col_addr,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [LEN_W-1:0] data_len,
  input  logic [8:0]       cmd2_word,
  input  logic [TWB_W-1:0] twb_cycles,
  input  logic [7:0]       wr_byte,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb,
  output logic [1:0]       nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  output logic             wr_pop,
  output logic             rd_valid,
  output logic [7:0]       rd_byte,
  output logic             busy,
  output logic             done_set,
  output logic             err_set
);

  localparam int AB_W     = COL_W + ROW_W;
  localparam int ADDR_MAX = AB_W / 8;
  localparam int CNT_W    = (LEN_W > TWB_W) ? LEN_W : TWB_W;

  seq_state_e       st_q, st_d;
  logic             ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  op_cfg_t          cfg_q;
  logic [AB_W-1:0]  ab_q;
  logic [LEN_W-1:0] len_q;
  logic [8:0]       c2_q;
  logic [TWB_W-1:0] twb_q;
  logic             rdv_q;
  logic [7:0]       rdb_q;

  logic start, byte_st, last_byte, has_data, is_rd, is_wr, rd_cap;
  logic go_addr, go_data, go_c2;
  logic [7:0] addr_byte;

  assign start    = launch & (st_q == ST_IDLE);
  assign err_set  = launch & (st_q != ST_IDLE);
  assign busy     = (st_q != ST_IDLE);
  assign is_rd    = cfg_q.rd;
  assign is_wr    = cfg_q.wr & ~cfg_q.rd;
  assign has_data = (cfg_q.rd | cfg_q.wr) & (len_q != '0);
  assign byte_st  = (st_q == ST_CMD1) | (st_q == ST_ADDR) | (st_q == ST_DATA) | (st_q == ST_CMD2);
  assign rd_cap   = (st_q == ST_DATA) & is_rd & ~ph_q;

  always_comb begin
    case (st_q)
      ST_ADDR: last_byte = (cnt_q == CNT_W'(cfg_q.naddr) - CNT_W'(1));
      ST_DATA: last_byte = (cnt_q == CNT_W'(len_q) - CNT_W'(1));
      default: last_byte = 1'b1;
    endcase
  end

  always_comb begin
    addr_byte = 8'h00;
    for (int i = 0; i < ADDR_MAX; i++)
      if (cnt_q == CNT_W'(i)) addr_byte = ab_q[i*8 +: 8];
  end

  always_comb begin
    go_addr = (st_q == ST_CMD1) & (cfg_q.naddr != 3'd0);
    go_data = ((st_q == ST_CMD1) | (st_q == ST_ADDR)) & has_data;
    go_c2   = (st_q != ST_CMD2) & c2_q[C2_EN];
  end

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    done_set = 1'b0;
    if (st_q == ST_IDLE) begin
      if (start) begin
        st_d = ST_CMD1;
        ph_d = 1'b0;
      end
    end else if (byte_st) begin
      ph_d = ~ph_q;
      if (ph_q) begin
        if (!last_byte) begin
          cnt_d = cnt_q + CNT_W'(1);
        end else begin
          cnt_d = '0;
          if (go_addr)      st_d = ST_ADDR;
          else if (go_data) st_d = ST_DATA;
          else if (go_c2)   st_d = ST_CMD2;
          else begin
            st_d  = ST_TWB;
            cnt_d = CNT_W'(twb_q);
          end
        end
      end
    end else if (st_q == ST_TWB) begin
      if (cnt_q == '0) st_d = ST_WAIT;
      else             cnt_d = cnt_q - CNT_W'(1);
    end else if (st_q == ST_WAIT) begin
      if (nand_rb) begin
        st_d     = ST_IDLE;
        done_set = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= 1'b0;
      cnt_q <= '0;
      rdv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      rdv_q <= rd_cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ab_q  <= '0;
      len_q <= '0;
      c2_q  <= '0;
      twb_q <= '0;
    end else if (start) begin
      cfg_q <= cfg_in;
      ab_q  <= {row_addr, col_addr};
      len_q <= data_len;
      c2_q  <= cmd2_word;
      twb_q <= twb_cycles;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdb_q <= 8'h00;
    else if (rd_cap) rdb_q <= nand_dq_in;
  end

  always_comb begin
    nand_ce_n   = busy ? (cfg_q.cs ? 2'b01 : 2'b10) : 2'b11;
    nand_cle    = (st_q == ST_CMD1) | (st_q == ST_CMD2);
    nand_ale    = (st_q == ST_ADDR);
    nand_dq_oe  = nand_cle | nand_ale | ((st_q == ST_DATA) & is_wr);
    nand_we_n   = ~(~ph_q & nand_dq_oe);
    nand_re_n   = ~(~ph_q & (st_q == ST_DATA) & is_rd);
    wr_pop      = (st_q == ST_DATA) & is_wr & ph_q;
    case (st_q)
      ST_CMD1: nand_dq_out = cfg_q.opcode;
      ST_ADDR: nand_dq_out = addr_byte;
      ST_CMD2: nand_dq_out = c2_q[7:0];
      ST_DATA: nand_dq_out = is_wr ? wr_byte : 8'h00;
      default: nand_dq_out = 8'h00;
    endcase
    rd_valid = rdv_q;
    rd_byte  = rdb_q;
  end

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy) |=> busy);

  // R2
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n) |=> nand_we_n);

  // R5
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_re_n) |=> (rd_valid && nand_re_n));

  // R9
  ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(nand_ce_n));

  // R10
  rb_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !nand_rb) |=> busy);

  // R12
  busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && busy && st_q != ST_WAIT) |=> busy);

endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int COL_W = 16,
  parameter int ROW_W = 24,
  parameter int LEN_W = 12,
  parameter int TWB_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_word,
  input  logic [COL_W-1:0] col_addr,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [LEN_W-1:0] data_len,
  input  logic [8:0]       cmd2_word,
  input  logic [TWB_W-1:0] twb_cycles,
  input  logic             irq_we,
  input  logic [31:0]      irq_wdata,
  input  logic [7:0]       wr_byte,
  output logic             wr_pop,
  output logic             rd_valid,
  output logic [7:0]       rd_byte,
  output logic [1:0]       nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_in,
  input  logic             nand_rb,
  output logic             busy,
  output logic             done_flag,
  output logic             err_flag
);

  localparam int ADDR_MAX = (COL_W + ROW_W) / 8;

  op_cfg_t cfg;
  logic    go;
  logic    launch;
  logic    done_set;
  logic    err_set;
  logic    unused_irq;

  assign launch     = ctl_we & go;
  assign unused_irq = ^irq_wdata[29:0];

  nand_seq_decode #(.ADDR_MAX(ADDR_MAX)) i_decode (
    .word (ctl_word),
    .go   (go),
    .cfg  (cfg)
  );

  nand_seq_fsm #(
    .COL_W(COL_W), .ROW_W(ROW_W), .LEN_W(LEN_W), .TWB_W(TWB_W)
  ) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .cfg_in      (cfg),
    .col_addr    (col_addr),
    .row_addr    (row_addr),
    .data_len    (data_len),
    .cmd2_word   (cmd2_word),
    .twb_cycles  (twb_cycles),
    .wr_byte     (wr_byte),
    .nand_dq_in  (nand_dq_in),
    .nand_rb     (nand_rb),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_out (nand_dq_out),
    .nand_dq_oe  (nand_dq_oe),
    .wr_pop      (wr_pop),
    .rd_valid    (rd_valid),
    .rd_byte     (rd_byte),
    .busy        (busy),
    .done_set    (done_set),
    .err_set     (err_set)
  );

  nand_seq_flags i_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_set (done_set),
    .err_set  (err_set),
    .clr_we   (irq_we),
    .clr_done (irq_wdata[IRQ_DONE]),
    .clr_err  (irq_wdata[IRQ_ERR]),
    .done_q   (done_flag),
    .err_q    (err_flag)
  );

endmodule

// File: tb/test_nand_seq.sv
module test_nand_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_word = '0;
  logic [15:0] col_addr = '0;
  logic [23:0] row_addr = '0;
  logic [11:0] data_len = '0;
  logic [8:0]  cmd2_word = '0;
  logic [7:0]  twb_cycles = '0;
  logic        irq_we = 1'b0;
  logic [31:0] irq_wdata = '0;
  logic [7:0]  wr_byte;
  logic        wr_pop, rd_valid;
  logic [7:0]  rd_byte;
  logic [1:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = 8'h00;
  logic        nand_rb = 1'b1;
  logic        busy, done_flag, err_flag;

  int checks = 0;
  int errors = 0;
  int wcount = 0;
  bit reported = 0;

  typedef struct {
    logic [25:0] exp;
    string       req;
    logic        rb;
    logic [7:0]  din;
  } item_t;

  item_t q[$];

  always #5 clk = ~clk;

  assign wr_byte = 8'h3C ^ wcount[7:0];

  nand_seq i_nand_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_word(ctl_word),
    .col_addr(col_addr), .row_addr(row_addr), .data_len(data_len),
    .cmd2_word(cmd2_word), .twb_cycles(twb_cycles), .irq_we(irq_we),
    .irq_wdata(irq_wdata), .wr_byte(wr_byte), .wr_pop(wr_pop),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb), .busy(busy),
    .done_flag(done_flag), .err_flag(err_flag)
  );

  function automatic logic [25:0] mk(input logic b, input logic [1:0] ce,
      input logic cle, input logic ale, input logic we, input logic re,
      input logic oe, input logic [7:0] dq, input logic pop,
      input logic rv, input logic [7:0] rb);
    return {b, ce, cle, ale, we, re, oe, dq, pop, rv, rb};
  endfunction

  localparam logic [25:0] IDLE_V = {1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [25:0] e, input string req, input logic rb, input logic [7:0] din);
    item_t it;
    it.exp = e; it.req = req; it.rb = rb; it.din = din;
    q.push_back(it);
  endtask

  // Expand one launch into the expected per-clock bus trace.
  task automatic build(input logic [31:0] w, input logic [15:0] col, input logic [23:0] row,
                       input int len, input logic [8:0] c2, input int twb, input int k,
                       input string c2tag);
    logic [1:0] ce;
    logic [3:0] f;
    bit rd, wr;
    int na, wbase;
    logic [7:0] ab, b;
    ce = w[19] ? 2'b01 : 2'b10;
    rd = w[26];
    wr = w[25] && !w[26];
    f  = w[30:27];
    na = f[3] ? ((int'(f[2:0]) + 1 > 5) ? 5 : int'(f[2:0]) + 1) : 0;
    wbase = wcount;
    push(mk(1, ce, 1, 0, 0, 1, 1, w[7:0], 0, 0, 8'h00), "R2", 1, 8'h00);
    push(mk(1, ce, 1, 0, 1, 1, 1, w[7:0], 0, 0, 8'h00), "R2", 1, 8'h00);
    for (int i = 0; i < na; i++) begin
      ab = (i < 2) ? col[8*i +: 8] : row[8*(i-2) +: 8];
      push(mk(1, ce, 0, 1, 0, 1, 1, ab, 0, 0, 8'h00), "R3 R4", 1, 8'h00);
      push(mk(1, ce, 0, 1, 1, 1, 1, ab, 0, 0, 8'h00), "R3 R4", 1, 8'h00);
    end
    if ((rd || wr) && len > 0) begin
      for (int j = 0; j < len; j++) begin
        if (rd) begin
          b = 8'h5A ^ 8'(j * 7);
          push(mk(1, ce, 0, 0, 1, 0, 0, 8'h00, 0, 0, 8'h00), "R5", 1, b);
          push(mk(1, ce, 0, 0, 1, 1, 0, 8'h00, 0, 1, b), "R5", 1, 8'h00);
        end else begin
          b = 8'h3C ^ 8'(wbase + j);
          push(mk(1, ce, 0, 0, 0, 1, 1, b, 0, 0, 8'h00), "R6", 1, 8'h00);
          push(mk(1, ce, 0, 0, 1, 1, 1, b, 1, 0, 8'h00), "R6", 1, 8'h00);
        end
      end
    end
    if (c2[8]) begin
      push(mk(1, ce, 1, 0, 0, 1, 1, c2[7:0], 0, 0, 8'h00), c2tag, 1, 8'h00);
      push(mk(1, ce, 1, 0, 1, 1, 1, c2[7:0], 0, 0, 8'h00), c2tag, 1, 8'h00);
    end
    // R10: ready is held high through the settle window and must be ignored
    for (int i = 0; i <= twb; i++)
      push(mk(1, ce, 0, 0, 1, 1, 0, 8'h00, 0, 0, 8'h00), "R10", 1, 8'h00);
    for (int i = 0; i < k; i++)
      push(mk(1, ce, 0, 0, 1, 1, 0, 8'h00, 0, 0, 8'h00), "R10", 0, 8'h00);
    push(mk(1, ce, 0, 0, 1, 1, 0, 8'h00, 0, 0, 8'h00), "R10", 1, 8'h00);
  endtask

  // Per-clock comparison against the expected trace.
  always @(negedge clk) begin
    if (rst_n) begin
      logic [25:0] obs;
      obs = {busy, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe,
             nand_dq_oe ? nand_dq_out : 8'h00, wr_pop, rd_valid,
             rd_valid ? rd_byte : 8'h00};
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        chk(obs == it.exp, it.req, 32'(obs), 32'(it.exp));
        nand_rb    <= it.rb;
        nand_dq_in <= it.din;
      end else begin
        chk(obs == IDLE_V, "R1 idle", 32'(obs), 32'(IDLE_V));
      end
      if (wr_pop) wcount++;
    end
  end

  task automatic start_op(input logic [31:0] w, input logic [15:0] col, input logic [23:0] row,
                          input int len, input logic [8:0] c2, input int twb, input int k,
                          input string c2tag);
    @(negedge clk);
    ctl_word = w; col_addr = col; row_addr = row; data_len = 12'(len);
    cmd2_word = c2; twb_cycles = 8'(twb); ctl_we = 1'b1;
    @(posedge clk);
    #1;
    ctl_we = 1'b0;
    build(w, col, row, len, c2, twb, k, c2tag);
  endtask

  task automatic wait_end;
    while (q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr(input logic [31:0] d);
    @(negedge clk);
    irq_we = 1'b1; irq_wdata = d;
    @(posedge clk);
    #1;
    irq_we = 1'b0; irq_wdata = '0;
    @(negedge clk);
  endtask

  task automatic report;
    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 R12: flags clear after reset
    chk(done_flag == 1'b0, "R11 reset", 32'(done_flag), 0);
    chk(err_flag == 1'b0, "R12 reset", 32'(err_flag), 0);
    repeat (2) @(negedge clk);

    // Page read: 5 address cycles, read start confirm, CE0
    start_op(32'h8000_0000 | (32'hC << 27) | (32'h1 << 26) | 32'h00,
             16'h0234, 24'h56789A, 6, 9'h130, 3, 4, "R8");
    wait_end();
    chk(done_flag == 1'b1, "R10 done", 32'(done_flag), 1);
    // R11: clear write with bit 31 clear leaves done set
    clr(32'h0000_0001);
    chk(done_flag == 1'b1, "R11 keep", 32'(done_flag), 1);
    clr(32'h8000_0000);
    chk(done_flag == 1'b0, "R11 clear", 32'(done_flag), 0);

    // Program on CE1, 4 address cycles, write phase, confirm; busy launch mid-way
    start_op(32'h8000_0000 | (32'hB << 27) | (32'h1 << 25) | (32'h1 << 19) | 32'h80,
             16'h1100, 24'h000302, 5, 9'h110, 0, 2, "R8");
    repeat (4) @(negedge clk);
    // R9: CE1 selected
    chk(nand_ce_n == 2'b01, "R9", 32'(nand_ce_n), 32'h1);
    ctl_word = 32'h8000_00FF | (32'h1 << 26); ctl_we = 1'b1;
    @(posedge clk);
    #1;
    ctl_we = 1'b0;
    wait_end();
    chk(err_flag == 1'b1, "R12 set", 32'(err_flag), 1);
    chk(done_flag == 1'b1, "R12 op completes", 32'(done_flag), 1);
    clr(32'h4000_0000);
    chk(err_flag == 1'b0, "R12 clear", 32'(err_flag), 0);
    chk(done_flag == 1'b1, "R11 err clear keeps done", 32'(done_flag), 1);
    clr(32'hC000_0000);

    // Status read: single address cycle, short read, no confirm
    start_op(32'h8000_0000 | (32'h8 << 27) | (32'h1 << 26) | 32'h70,
             16'h0000, 24'h0, 2, 9'h070, 1, 0, "R8");
    wait_end();
    clr(32'h8000_0000);

    // R7: erase with write bit but zero length, 3 address cycles
    start_op(32'h8000_0000 | (32'hA << 27) | (32'h1 << 25) | 32'h60,
             16'hBEEF, 24'h0A0B0C, 0, 9'h1D0, 2, 3, "R7 R8");
    wait_end();
    clr(32'h8000_0000);

    // R3 cap and R5 precedence: field 15, both direction bits
    start_op(32'h8000_0000 | (32'hF << 27) | (32'h3 << 25) | 32'h05,
             16'hA1B2, 24'hC3D4E5, 3, 9'h1E0, 0, 1, "R8");
    wait_end();
    clr(32'h8000_0000);

    // R3: no address, no data, no confirm
    start_op(32'h8000_00FF, 16'h0, 24'h0, 4, 9'h0AA, 2, 2, "R8");
    wait_end();
    chk(done_flag == 1'b1, "R10 done", 32'(done_flag), 1);
    clr(32'h8000_0000);

    // R1: write without start bit has no effect
    @(negedge clk);
    ctl_word = 32'h7FFF_FFFF; ctl_we = 1'b1;
    @(posedge clk);
    #1;
    ctl_we = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R1 ignored", 32'(busy), 0);
    chk(done_flag == 1'b0, "R1 no done", 32'(done_flag), 0);
    report();
  end

endmodule